// File: doc/BRIEF.md
# Host Configuration and Coefficient Port

This block is the host side of a decimating filter. A processor reaches it over a byte-wide data path with a 3-bit address and two active-low strobes, one for writing and one for reading. Behind the port sit eight 8-bit configuration slots and a bank of 128 coefficient words, each 32 bits wide. The port decodes the main configuration fields and presents them to the filter. The filter reads coefficients through a separate read-only index port.

Coefficients all share one address, 2. Every write there places one byte in a holding register, least-significant byte first. The fourth byte of a group completes the word, writes it into the bank at the current pointer and moves the pointer on. The pointer stops at the last entry. A mode bit in slot 0 chooses between loading and reading back. In readback mode, reads from address 2 return the current word one byte at a time, and the pointer moves on after the fourth byte.

Both strobes come from a clock domain of their own. The block synchronizes them into the system clock and acts on the falling edge of each. The address and data must stay stable while a strobe is low. The bidirectional bus is split into an input, an output and an output enable, and the pad tristate sits outside the block.

Top module: `cfgHostPort`

## Requirements
- R1: After reset every configuration slot is 0. The decoded outputs are then: decimation 8, tap count 256, halfband count 0, filter enable off, load mode. The output enable is low.
- R2: A write stores the data present at the falling edge of the write strobe into the addressed slot, for addresses 0, 1 and 3 to 7. While a later read strobe is low, the output enable is high and the slot value is on the output. The enable goes low once the read strobe returns high.
- R3: Slot 0 is decoded as follows. Bits 2:0 are the halfband count, and the valid flag is set only for counts 0 to 5. Bit 3 is the filter enable. Bits 7:5 are the decimation rate, with 000 read as 8 and any other code as its own value.
- R4: Slot 1 is the tap count, with 0 read as 256. The tap-count valid flag is clear for the values 1, 2 and 3 and set for every other value.
- R5: In load mode (slot 0 bit 4 = 0), writes to address 2 collect bytes least-significant first. The first three bytes of a group leave the bank unchanged. The fourth byte writes the whole word into the entry at the pointer, and the filter index port then shows it.
- R6: The pointer moves on by one after each completed word, up to entry 127. Later words overwrite entry 127 and leave all other entries unchanged.
- R7: In readback mode (slot 0 bit 4 = 1), writes to address 2 change no entry. In load mode, reads from address 2 return 0x00 and do not move the pointer.
- R8: In readback mode, four reads from address 2 return the word at the pointer, least-significant byte first. The pointer then moves on to the next entry.
- R9: A write to slot 0 that changes bit 4 sets the pointer and the byte position back to entry 0, byte 0.
- R10: A strobe that falls while the other strobe is low is ignored, and so are two strobes that fall together. Such a write changes no slot, and such a read does not set the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Host address |
| hostWrN | input | 1 | Active-low write strobe, asynchronous |
| hostRdN | input | 1 | Active-low read strobe, asynchronous |
| hostDataIn | input | 8 | Byte from the host bus |
| hostDataOut | output | 8 | Byte driven onto the host bus |
| hostDataOe | output | 1 | Enable for the bus driver |
| coefRdIdx | input | 7 | Filter-side coefficient index |
| coefRdData | output | 32 | Coefficient at coefRdIdx |
| halfbandCount | output | 3 | Halfband stage count |
| halfbandValid | output | 1 | Halfband count is 0 to 5 |
| filterEnable | output | 1 | Filter enable bit |
| coefReadMode | output | 1 | Readback mode (slot 0 bit 4) |
| decimRate | output | 4 | Decimation rate, 1 to 8 |
| tapCount | output | 9 | Tap count, 1 to 256 |
| tapCountValid | output | 1 | Tap count is not 1, 2 or 3 |
| auxRegs | output | 40 | Slots 3 to 7, slot 3 in bits 7:0 |

## Verification
A host read and a host write can both be pending at the same time, one strobe falling while the other is already low or both falling together. The bench provokes both cases. In the first, it holds the read strobe low and then drops the write strobe on a configuration slot. In the second, it drops both strobes at the same instant. It then checks that the output enable matches a legal read (high in the first case, low in the second). It also reads the slot back afterwards to confirm that the overlapping write left it unchanged.

// File: rtl/cfgPortPkg.sv
package cfgPortPkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int BYTE_IDX_W = 2;
  localparam logic [ADDR_W-1:0] COEF_ADDR = 3'd2;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 3'd0;
  localparam int MODE_BIT = 4;

  typedef struct packed {
    logic regWrite;
    logic holdLoad;
    logic coefCommit;
    logic ptrAdvance;
    logic readLoad;
    logic seqClear;
    logic [BYTE_IDX_W-1:0] byteIdx;
  } portStrobeT;
endpackage

// File: rtl/hostStrobeSync.sv
module hostStrobeSync #(
  parameter int STAGES = 2,
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] strobeN,
  output logic [NUM-1:0] level,
  output logic [NUM-1:0] fall
);
  for (genvar i = 0; i < NUM; i++) begin : gSync
    logic [STAGES-1:0] chain;
    logic prevLevel;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain <= '1;
        prevLevel <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], strobeN[i]};
        prevLevel <= chain[STAGES-1];
      end
    end
    assign level[i] = chain[STAGES-1];
    assign fall[i] = prevLevel && !chain[STAGES-1];
  end
endmodule

// File: rtl/cfgPortCtrl.sv
module cfgPortCtrl
  import cfgPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrFall,
  input  logic              rdFall,
  input  logic              wrLevel,
  input  logic              rdLevel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              coefReadMode,
  output portStrobeT        strobe,
  output logic              dataOe
);
  logic [BYTE_IDX_W-1:0] byteCnt;
  logic legalWr, legalRd, isCoef, lastByte, coefStep;

  assign legalWr = wrFall && rdLevel;
  assign legalRd = rdFall && wrLevel;
  assign isCoef = (addr == COEF_ADDR);
  assign lastByte = (byteCnt == '1);
  assign coefStep = (legalWr && isCoef && !coefReadMode) ||
                    (legalRd && isCoef && coefReadMode);

  always_comb begin
    strobe = '0;
    strobe.byteIdx = byteCnt;
    if (legalWr) begin
      if (!isCoef) begin
        strobe.regWrite = 1'b1;
        if (addr == MODE_ADDR && wrData[MODE_BIT] != coefReadMode)
          strobe.seqClear = 1'b1;
      end else if (!coefReadMode) begin
        if (lastByte) begin
          strobe.coefCommit = 1'b1;
          strobe.ptrAdvance = 1'b1;
        end else begin
          strobe.holdLoad = 1'b1;
        end
      end
    end
    if (legalRd) begin
      strobe.readLoad = 1'b1;
      if (isCoef && coefReadMode && lastByte) strobe.ptrAdvance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      dataOe <= 1'b0;
    end else begin
      if (strobe.seqClear) byteCnt <= '0;
      else if (coefStep) byteCnt <= byteCnt + 1'b1;
      if (legalRd) dataOe <= 1'b1;
      else if (rdLevel) dataOe <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgPortDatapath.sv
module cfgPortDatapath
  import cfgPortPkg::*;
#(
  parameter int NUM_ENTRIES = 128,
  parameter int COEF_W = 32,
  parameter int REG_COUNT = 8,
  localparam int PTR_W = $clog2(NUM_ENTRIES),
  localparam int BYTES = COEF_W / BYTE_W,
  localparam int HOLD_W = (BYTES - 1) * BYTE_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  portStrobeT                      strobe,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [BYTE_W-1:0]               wrData,
  input  logic [PTR_W-1:0]                coefRdIdx,
  output logic [COEF_W-1:0]               coefRdData,
  output logic [BYTE_W-1:0]               readData,
  output logic [2*BYTE_W-1:0]             cfgLow,
  output logic [(REG_COUNT-3)*BYTE_W-1:0] cfgHigh,
  output logic [PTR_W-1:0]                coefPtr,
  output logic                            coefReadMode
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ENTRIES - 1);

  logic [REG_COUNT*BYTE_W-1:0] regFile;
  logic [HOLD_W-1:0] holdReg;
  logic [COEF_W-1:0] coefBank [NUM_ENTRIES];
  logic [COEF_W-1:0] curWord;

  for (genvar i = 0; i < REG_COUNT; i++) begin : gReg
    if (i == int'(COEF_ADDR)) begin : gNone
      assign regFile[i*BYTE_W +: BYTE_W] = '0;
    end else begin : gFlop
      always_ff @(posedge clk) begin
        if (!rstN) regFile[i*BYTE_W +: BYTE_W] <= '0;
        else if (strobe.regWrite && addr == ADDR_W'(i))
          regFile[i*BYTE_W +: BYTE_W] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdReg <= '0;
    else if (strobe.holdLoad) holdReg[strobe.byteIdx*BYTE_W +: BYTE_W] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.coefCommit) coefBank[coefPtr] <= {wrData, holdReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) coefPtr <= '0;
    else if (strobe.seqClear) coefPtr <= '0;
    else if (strobe.ptrAdvance && coefPtr != LAST) coefPtr <= coefPtr + 1'b1;
  end

  assign curWord = coefBank[coefPtr];

  always_ff @(posedge clk) begin
    if (!rstN) readData <= '0;
    else if (strobe.readLoad) begin
      if (addr == COEF_ADDR)
        readData <= coefReadMode ? curWord[strobe.byteIdx*BYTE_W +: BYTE_W] : '0;
      else
        readData <= regFile[addr*BYTE_W +: BYTE_W];
    end
  end

  assign coefRdData = coefBank[coefRdIdx];
  assign cfgLow = regFile[2*BYTE_W-1:0];
  assign cfgHigh = regFile[REG_COUNT*BYTE_W-1:3*BYTE_W];
  assign coefReadMode = regFile[MODE_BIT];
endmodule

// File: rtl/cfgHostPort.sv
module cfgHostPort
  import cfgPortPkg::*;
#(
  parameter int NUM_ENTRIES = 128,
  parameter int COEF_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrN,
  input  logic              hostRdN,
  input  logic [7:0]        hostDataIn,
  output logic [7:0]        hostDataOut,
  output logic              hostDataOe,
  input  logic [PTR_W-1:0]  coefRdIdx,
  output logic [COEF_W-1:0] coefRdData,
  output logic [2:0]        halfbandCount,
  output logic              halfbandValid,
  output logic              filterEnable,
  output logic              coefReadMode,
  output logic [3:0]        decimRate,
  output logic [8:0]        tapCount,
  output logic              tapCountValid,
  output logic [39:0]       auxRegs
);
  logic [1:0] level, fall;
  logic wrLevel, rdLevel, wrFall, rdFall;
  portStrobeT strobe;
  logic [15:0] cfgLow;
  logic [PTR_W-1:0] coefPtr;

  hostStrobeSync #(.STAGES(SYNC_STAGES), .NUM(2)) uSync (
    .clk(clk), .rstN(rstN), .strobeN({hostRdN, hostWrN}), .level(level), .fall(fall)
  );
  assign wrLevel = level[0];
  assign rdLevel = level[1];
  assign wrFall = fall[0];
  assign rdFall = fall[1];

  cfgPortCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrFall(wrFall), .rdFall(rdFall),
    .wrLevel(wrLevel), .rdLevel(rdLevel), .addr(hostAddr), .wrData(hostDataIn),
    .coefReadMode(coefReadMode), .strobe(strobe), .dataOe(hostDataOe)
  );

  cfgPortDatapath #(.NUM_ENTRIES(NUM_ENTRIES), .COEF_W(COEF_W), .REG_COUNT(8)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(hostAddr), .wrData(hostDataIn),
    .coefRdIdx(coefRdIdx), .coefRdData(coefRdData), .readData(hostDataOut),
    .cfgLow(cfgLow), .cfgHigh(auxRegs), .coefPtr(coefPtr), .coefReadMode(coefReadMode)
  );

  assign halfbandCount = cfgLow[2:0];
  assign halfbandValid = (cfgLow[2:0] <= 3'd5);
  assign filterEnable = cfgLow[3];
  assign decimRate = (cfgLow[7:5] == 3'd0) ? 4'd8 : {1'b0, cfgLow[7:5]};
  assign tapCount = (cfgLow[15:8] == 8'd0) ? 9'd256 : {1'b0, cfgLow[15:8]};
  assign tapCountValid = (cfgLow[15:8] == 8'd0) || (cfgLow[15:8] >= 8'd4);
endmodule

// File: rtl/cfgHostPortChecker.sv
module cfgHostPortChecker
  import cfgPortPkg::*;
#(
  parameter int PTR_W = 7,
  parameter int NUM_ENTRIES = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrLevel,
  input logic             rdLevel,
  input logic             wrFall,
  input logic             rdFall,
  input logic             hostDataOe,
  input portStrobeT       strobe,
  input logic [PTR_W-1:0] coefPtr,
  input logic             coefReadMode,
  input logic [15:0]      cfgLow,
  input logic [39:0]      auxRegs
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ENTRIES - 1);

  assert_oe_released_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdLevel && $past(rdLevel)) |-> !hostDataOe);

  assert_oe_on_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdFall && wrLevel) |=> hostDataOe);

  assert_ptr_holds_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (coefPtr == LAST && !strobe.seqClear) |=> coefPtr == LAST);

  assert_no_load_in_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    coefReadMode |-> !(strobe.holdLoad || strobe.coefCommit));

  assert_ptr_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seqClear |=> coefPtr == '0);

  assert_overlap_write_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrFall && !rdLevel) |=> $stable({cfgLow, auxRegs}));

  assert_single_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.regWrite, strobe.holdLoad, strobe.coefCommit, strobe.readLoad}));
endmodule

bind cfgHostPort cfgHostPortChecker #(.PTR_W(PTR_W), .NUM_ENTRIES(NUM_ENTRIES)) uChk (
  .clk(clk), .rstN(rstN), .wrLevel(wrLevel), .rdLevel(rdLevel), .wrFall(wrFall),
  .rdFall(rdFall), .hostDataOe(hostDataOe), .strobe(strobe), .coefPtr(coefPtr),
  .coefReadMode(coefReadMode), .cfgLow(cfgLow), .auxRegs(auxRegs)
);

// File: tb/cfgHostPort_test.sv
`timescale 1ns/1ps
module cfgHostPort_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic hostWrN = 1'b1, hostRdN = 1'b1;
  logic [7:0] hostDataIn = '0;
  logic [7:0] hostDataOut;
  logic hostDataOe;
  logic [6:0] coefRdIdx = '0;
  logic [31:0] coefRdData;
  logic [2:0] halfbandCount;
  logic halfbandValid, filterEnable, coefReadMode, tapCountValid;
  logic [3:0] decimRate;
  logic [8:0] tapCount;
  logic [39:0] auxRegs;

  int errors = 0, checks = 0;
  logic [7:0] regModel [8];
  logic [31:0] bankModel [128];
  logic [7:0] rdByte;
  logic rdOe;

  always #2 clk = ~clk;

  cfgHostPort uut (.*);

  function automatic logic [3:0] expDecim(input logic [7:0] r);
    return (r[7:5] == 0) ? 4'd8 : {1'b0, r[7:5]};
  endfunction
  function automatic logic [8:0] expTaps(input logic [7:0] r);
    return (r == 0) ? 9'd256 : {1'b0, r};
  endfunction
  function automatic logic expTapOk(input logic [7:0] r);
    return !(r >= 1 && r <= 3);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    hostAddr = a; hostDataIn = d; hostWrN = 1'b0;
    repeat (4) @(posedge clk); #1;
    hostWrN = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d, output logic oe);
    @(posedge clk); #1;
    hostAddr = a; hostRdN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    d = hostDataOut; oe = hostDataOe;
    @(posedge clk); #1;
    hostRdN = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 enable released", {63'd0, hostDataOe}, 64'd0);
  endtask

  task automatic coefWord(input logic [31:0] w);
    for (int b = 0; b < 4; b++) hostWrite(3'd2, w[b*8 +: 8]);
  endtask

  task automatic checkDecode(input string tag);
    @(negedge clk);
    check({tag, " R3 halfbands"}, {61'd0, halfbandCount}, {61'd0, regModel[0][2:0]});
    check({tag, " R3 halfband valid"}, {63'd0, halfbandValid}, {63'd0, regModel[0][2:0] <= 5});
    check({tag, " R3 enable"}, {63'd0, filterEnable}, {63'd0, regModel[0][3]});
    check({tag, " R3 decimation"}, {60'd0, decimRate}, {60'd0, expDecim(regModel[0])});
    check({tag, " R4 taps"}, {55'd0, tapCount}, {55'd0, expTaps(regModel[1])});
    check({tag, " R4 taps valid"}, {63'd0, tapCountValid}, {63'd0, expTapOk(regModel[1])});
    check({tag, " R2 aux"}, {24'd0, auxRegs},
          {24'd0, regModel[7], regModel[6], regModel[5], regModel[4], regModel[3]});
  endtask

  task automatic checkBank(input string tag);
    int bad = 0;
    for (int i = 0; i < 128; i++) begin
      coefRdIdx = 7'(i); #1;
      if (coefRdData !== bankModel[i]) begin
        if (bad == 0) $display("FAIL %s entry %0d actual=%0h expected=%0h", tag, i, coefRdData, bankModel[i]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [2:0] a;
    logic [31:0] w;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) regModel[i] = '0;
    repeat (4) @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", {63'd0, hostDataOe}, 64'd0);
    check("R1 decim", {60'd0, decimRate}, 64'd8);
    check("R1 taps", {55'd0, tapCount}, 64'd256);
    check("R1 mode", {63'd0, coefReadMode}, 64'd0);
    checkDecode("R1");

    // directed corners for R3 and R4
    regModel[0] = 8'b000_0_1_101; hostWrite(3'd0, regModel[0]); checkDecode("corner0");
    regModel[0] = 8'b111_0_0_110; hostWrite(3'd0, regModel[0]); checkDecode("corner1");
    for (int t = 0; t < 5; t++) begin
      regModel[1] = 8'(t); hostWrite(3'd1, regModel[1]); checkDecode("tapcorner");
    end

    // random configuration writes with readback, R2
    for (int i = 0; i < 40; i++) begin
      do a = 3'($urandom_range(0, 7)); while (a == 3'd2);
      v = 8'($urandom);
      if (a == 3'd0) v[4] = 1'b0;
      regModel[a] = v;
      hostWrite(a, v);
      hostRead(a, rdByte, rdOe);
      check("R2 oe during read", {63'd0, rdOe}, 64'd1);
      check("R2 readback", {56'd0, rdByte}, {56'd0, v});
      checkDecode("rand");
    end

    // R7 load mode read at coefficient address
    hostRead(3'd2, rdByte, rdOe);
    check("R7 load-mode coef read", {56'd0, rdByte}, 64'd0);

    // R5/R6 fill bank past the end
    for (int i = 0; i < 130; i++) begin
      w = $urandom;
      bankModel[(i > 127) ? 127 : i] = w;
      coefWord(w);
    end
    checkBank("R5 R6 bank fill");

    // R8 readback mode, R9 pointer cleared by mode change
    regModel[0][4] = 1'b1; hostWrite(3'd0, regModel[0]);
    hostRead(3'd2, rdByte, rdOe);
    check("R8 partial byte0", {56'd0, rdByte}, {56'd0, bankModel[0][7:0]});
    hostRead(3'd2, rdByte, rdOe);
    regModel[0][4] = 1'b0; hostWrite(3'd0, regModel[0]);
    regModel[0][4] = 1'b1; hostWrite(3'd0, regModel[0]);
    for (int e = 0; e < 3; e++)
      for (int b = 0; b < 4; b++) begin
        hostRead(3'd2, rdByte, rdOe);
        check($sformatf("R8 R9 entry%0d byte%0d", e, b), {56'd0, rdByte}, {56'd0, bankModel[e][b*8 +: 8]});
      end

    // R7 writes ignored in readback mode
    coefWord(32'hDEADBEEF);
    checkBank("R7 readback-mode write");

    // R5 partial burst over entry 0
    regModel[0][4] = 1'b0; hostWrite(3'd0, regModel[0]);
    hostWrite(3'd2, 8'h11); hostWrite(3'd2, 8'h22); hostWrite(3'd2, 8'h33);
    checkBank("R5 three bytes no commit");
    hostWrite(3'd2, 8'h44);
    bankModel[0] = 32'h44332211;
    checkBank("R5 fourth byte commit");

    // R10 write while read held low
    regModel[3] = 8'h5A; hostWrite(3'd3, 8'h5A);
    @(posedge clk); #1;
    hostAddr = 3'd3; hostRdN = 1'b0;
    repeat (4) @(posedge clk); #1;
    hostDataIn = 8'hA5; hostWrN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10 legal read oe", {63'd0, hostDataOe}, 64'd1);
    @(posedge clk); #1;
    hostWrN = 1'b1; hostRdN = 1'b1;
    repeat (5) @(posedge clk);
    hostRead(3'd3, rdByte, rdOe);
    check("R10 overlap write ignored", {56'd0, rdByte}, 64'h5A);

    // R10 both strobes fall together
    regModel[4] = 8'h3C; hostWrite(3'd4, 8'h3C);
    @(posedge clk); #1;
    hostAddr = 3'd4; hostDataIn = 8'hC3; hostWrN = 1'b0; hostRdN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10 simultaneous oe", {63'd0, hostDataOe}, 64'd0);
    @(posedge clk); #1;
    hostWrN = 1'b1; hostRdN = 1'b1;
    repeat (5) @(posedge clk);
    hostRead(3'd4, rdByte, rdOe);
    check("R10 simultaneous write ignored", {56'd0, rdByte}, 64'h3C);
    checkDecode("final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule